// File: doc/BRIEF.md
# Primary-Transmitter Radio Mode Sequencer

This block sequences the operating modes of the transmitting side of a packet radio baseband. It takes a power-up control bit, a chip-enable pin, the TX FIFO empty flag, the no-acknowledge flag of the packet at the head of the FIFO, an auto-acknowledge enable and the retry delay and retry limit fields. From these it decides when the radio powers up, idles, settles its synthesiser, transmits, listens for an acknowledgement, backs off and retries. It also decides when it gives up on a packet.

All waits are counted in ticks of a one-microsecond strobe. The framer reports the end of a transmission and the arrival of an acknowledgement through single-cycle handshake inputs. The block times the acknowledgement window itself and counts a missed acknowledgement as a lost packet. It keeps a per-packet retry counter and a saturating lifetime loss counter. It reports a sent event and a max-retry event as single-cycle pulses. After a max-retry event it refuses to start any transmission until software clears the lockout.

States and transitions:
- MODE_OFF goes to MODE_IDLE1 after the start-up wait. Any state returns to MODE_OFF when power is removed.
- MODE_IDLE1 launches to MODE_TXSET.
- MODE_IDLE2 launches to MODE_TXSET, or drops to MODE_IDLE1.
- MODE_TXSET goes to MODE_TX.
- MODE_TX, on completion, goes to MODE_RXSET, or finishes to MODE_IDLE1, MODE_IDLE2 or back into MODE_TX.
- MODE_RXSET goes to MODE_RXWAIT.
- MODE_RXWAIT, on an acknowledgement, finishes to MODE_IDLE1, MODE_IDLE2 or MODE_TXSET. On a timeout it goes to MODE_BACKOFF, or gives up to MODE_IDLE1.
- MODE_BACKOFF retries to MODE_TXSET.

Top module: `ptx_mode_ctrl`

## Requirements
- R1: After reset the mode output reads 0 (MODE_OFF). Both counters, `max_rt_flag`, `rx_enable` and all pulses are 0. Mode codes are: 0 off, 1 standby-I, 2 standby-II, 3 TX settle, 4 TX, 5 RX settle, 6 RX wait-for-ACK, 7 retry backoff.
- R2: With `pwr_up` low the mode is 0 on the next cycle from any state. After `pwr_up` is set, the mode moves to 1 once START_US ticks have elapsed.
- R3: From mode 1 a transmission is launched only when three conditions hold: `chip_en` has been high for at least CE_MIN_US consecutive ticks, the FIFO is non-empty and `max_rt_flag` is clear.
- R4: Every entry into mode 4 from another mode passes through mode 3, which lasts SETTLE_US ticks. `tx_start` pulses for one cycle in the first cycle of each transmission.
- R5: When a transmission ends without acknowledgement handling, `sent_pulse` fires and the block then does one of three things. With `chip_en` low it goes to mode 1. With `chip_en` high and the FIFO non-empty it stays in mode 4 and pulses `tx_start` again. With `chip_en` high and the FIFO empty it goes to mode 2.
- R6: In mode 2 a non-empty FIFO moves the block to mode 3, and a low `chip_en` moves it to mode 1.
- R7: With `auto_ack_en` high and `no_ack_flag` low, the end of a transmission leads through mode 5 (SETTLE_US ticks) to mode 6, where `rx_enable` is high. An acknowledgement there fires `sent_pulse` and finishes as in R5, except that a non-empty FIFO leads to mode 3. If `no_ack_flag` is high, the end of the transmission is treated as in R5.
- R8: When ACK_WAIT_US ticks pass in mode 6 without an acknowledgement, the packet counts as lost. `lost_cnt` increments and saturates at 15.
- R9: After a loss, if `retry_cnt` is below `retry_limit`, the block waits in mode 7 for (`retry_delay`+1)×STEP_US ticks and then enters mode 3 with `retry_cnt` incremented. Otherwise it pulses `max_rt_pulse`, sets `max_rt_flag` and goes to mode 1. A limit of 0 therefore disables retries.
- R10: While `max_rt_flag` is set, no launch happens from mode 1 or mode 2. A one-cycle `maxrt_clear` clears the flag.
- R11: `retry_cnt` returns to 0 whenever a new packet starts, meaning a launch from standby or a next packet after a finished one.
- R12: A `chan_write` pulse clears `lost_cnt`, and takes priority over a simultaneous increment.
- R13: `sent_pulse` and `max_rt_pulse` are single-cycle and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| pwr_up | input | 1 | Power-up control bit |
| chip_en | input | 1 | Chip-enable pin |
| fifo_empty | input | 1 | TX FIFO holds no payload |
| no_ack_flag | input | 1 | Head packet requests no acknowledgement |
| auto_ack_en | input | 1 | Auto-acknowledge enabled |
| retry_delay | input | DLY_W | Backoff step count minus one |
| retry_limit | input | CNT_W | Maximum retransmissions |
| tx_done | input | 1 | Framer finished sending a packet |
| ack_rcvd | input | 1 | Acknowledgement received |
| chan_write | input | 1 | RF channel register written |
| maxrt_clear | input | 1 | Software clear of the max-retry flag |
| mode | output | 3 | Current mode code |
| tx_start | output | 1 | Start-of-transmission pulse |
| rx_enable | output | 1 | Receiver listening for acknowledgement |
| retry_cnt | output | CNT_W | Retransmissions of the current packet |
| lost_cnt | output | CNT_W | Saturating lifetime loss count |
| sent_pulse | output | 1 | Packet delivered event |
| max_rt_pulse | output | 1 | Retry limit reached event |
| max_rt_flag | output | 1 | Max-retry lockout |

## Verification
The assertions assume that the framer pulses `tx_done` only in mode 4, and that `ack_rcvd` arrives only in mode 6. Both are assumed to be one-cycle pulses. They also assume `maxrt_clear` is a single-cycle strobe. The stimulus raises each of these handshakes only after it has seen the matching mode on the output, and drops it at the next cycle. FIFO state and chip enable are changed only while the block sits in a mode where the requirements define their effect.

// File: rtl/ptx_mode_pkg.sv
package ptx_mode_pkg;
    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_IDLE1   = 3'd1,
        MODE_IDLE2   = 3'd2,
        MODE_TXSET   = 3'd3,
        MODE_TX      = 3'd4,
        MODE_RXSET   = 3'd5,
        MODE_RXWAIT  = 3'd6,
        MODE_BACKOFF = 3'd7
    } mode_e;
endpackage

// File: rtl/ptx_us_timer.sv
module ptx_us_timer #(
    parameter int W       = 12,
    parameter int RST_LEN = 1500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_LEN);
        else if (load)
            cnt <= len;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: a freshly loaded non-zero wait cannot report expiry on the following cycle
    assert_no_early_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len != '0) |=> !expired);
endmodule

// File: rtl/ptx_ce_qual.sv
module ptx_ce_qual #(
    parameter int MIN_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ce,
    output logic ok
);
    localparam int CW = $clog2(MIN_US + 1) + 1;
    localparam logic [CW-1:0] HELD = CW'(MIN_US);

    logic [CW-1:0] held_us;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_us <= '0;
        else if (!ce)
            held_us <= '0;
        else if (tick && held_us != HELD)
            held_us <= held_us + 1'b1;
    end

    assign ok = ce && (held_us == HELD);

    // R3: qualification is never granted to an enable that was low on the previous cycle
    assert_ce_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> $past(ce));
endmodule

// File: rtl/ptx_loss_counters.sv
module ptx_loss_counters #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retry_clr,
    input  logic          retry_inc,
    input  logic          lost_inc,
    input  logic          lost_clr,
    output logic [CW-1:0] retry_cnt,
    output logic [CW-1:0] lost_cnt
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            retry_cnt <= '0;
        else if (retry_clr)
            retry_cnt <= '0;
        else if (retry_inc && retry_cnt != TOP)
            retry_cnt <= retry_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lost_cnt <= '0;
        else if (lost_clr)
            lost_cnt <= '0;
        else if (lost_inc && lost_cnt != TOP)
            lost_cnt <= lost_cnt + 1'b1;
    end

    assert_lost_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lost_clr |=> lost_cnt >= $past(lost_cnt));
    assert_lost_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt == TOP && !lost_clr) |=> lost_cnt == TOP);
    assert_lost_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lost_clr |=> lost_cnt == '0);
    assert_retry_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        retry_clr |=> retry_cnt == '0);
endmodule

// File: rtl/ptx_mode_ctrl.sv
module ptx_mode_ctrl
    import ptx_mode_pkg::*;
#(
    parameter int START_US    = 1500,
    parameter int SETTLE_US   = 130,
    parameter int CE_MIN_US   = 10,
    parameter int ACK_WAIT_US = 250,
    parameter int STEP_US     = 250,
    parameter int DLY_W       = 4,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             pwr_up,
    input  logic             chip_en,
    input  logic             fifo_empty,
    input  logic             no_ack_flag,
    input  logic             auto_ack_en,
    input  logic [DLY_W-1:0] retry_delay,
    input  logic [CNT_W-1:0] retry_limit,
    input  logic             tx_done,
    input  logic             ack_rcvd,
    input  logic             chan_write,
    input  logic             maxrt_clear,
    output logic [2:0]       mode,
    output logic             tx_start,
    output logic             rx_enable,
    output logic [CNT_W-1:0] retry_cnt,
    output logic [CNT_W-1:0] lost_cnt,
    output logic             sent_pulse,
    output logic             max_rt_pulse,
    output logic             max_rt_flag
);
    localparam int BACKOFF_MAX = (1 << DLY_W) * STEP_US;
    localparam int LONG_A  = (START_US > SETTLE_US) ? START_US : SETTLE_US;
    localparam int LONG_B  = (ACK_WAIT_US > BACKOFF_MAX) ? ACK_WAIT_US : BACKOFF_MAX;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] LEN_START  = TW'(START_US);
    localparam logic [TW-1:0] LEN_SETTLE = TW'(SETTLE_US);
    localparam logic [TW-1:0] LEN_ACK    = TW'(ACK_WAIT_US);

    mode_e         state, state_nx;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_len, backoff_len;
    logic          ce_ok;
    logic          launch, ev_sent, ev_maxrt;
    logic          retry_clr, retry_inc, lost_inc;

    assign backoff_len = TW'((32'(retry_delay) + 32'd1) * 32'(STEP_US));

    ptx_us_timer #(.W(TW), .RST_LEN(START_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    ptx_ce_qual #(.MIN_US(CE_MIN_US)) u_ce_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .ce    (chip_en),
        .ok    (ce_ok)
    );

    ptx_loss_counters #(.CW(CNT_W)) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .retry_clr (retry_clr),
        .retry_inc (retry_inc),
        .lost_inc  (lost_inc),
        .lost_clr  (chan_write),
        .retry_cnt (retry_cnt),
        .lost_cnt  (lost_cnt)
    );

    // next-state and event decode
    always_comb begin
        state_nx  = state;
        tmr_load  = 1'b0;
        tmr_len   = LEN_SETTLE;
        launch    = 1'b0;
        ev_sent   = 1'b0;
        ev_maxrt  = 1'b0;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        lost_inc  = 1'b0;
        if (!pwr_up) begin
            state_nx = MODE_OFF;
            tmr_load = 1'b1;
            tmr_len  = LEN_START;
        end else begin
            unique case (state)
                MODE_OFF: begin
                    if (tmr_expired)
                        state_nx = MODE_IDLE1;
                end
                MODE_IDLE1: begin
                    if (ce_ok && !fifo_empty && !max_rt_flag) begin
                        state_nx  = MODE_TXSET;
                        tmr_load  = 1'b1;
                        retry_clr = 1'b1;
                    end
                end
                MODE_IDLE2: begin
                    if (!chip_en) begin
                        state_nx = MODE_IDLE1;
                    end else if (!fifo_empty && !max_rt_flag) begin
                        state_nx  = MODE_TXSET;
                        tmr_load  = 1'b1;
                        retry_clr = 1'b1;
                    end
                end
                MODE_TXSET: begin
                    if (tmr_expired) begin
                        state_nx = MODE_TX;
                        launch   = 1'b1;
                    end
                end
                MODE_TX: begin
                    if (tx_done) begin
                        if (auto_ack_en && !no_ack_flag) begin
                            state_nx = MODE_RXSET;
                            tmr_load = 1'b1;
                        end else begin
                            ev_sent = 1'b1;
                            if (!chip_en) begin
                                state_nx = MODE_IDLE1;
                            end else if (!fifo_empty) begin
                                launch    = 1'b1;
                                retry_clr = 1'b1;
                            end else begin
                                state_nx = MODE_IDLE2;
                            end
                        end
                    end
                end
                MODE_RXSET: begin
                    if (tmr_expired) begin
                        state_nx = MODE_RXWAIT;
                        tmr_load = 1'b1;
                        tmr_len  = LEN_ACK;
                    end
                end
                MODE_RXWAIT: begin
                    if (ack_rcvd) begin
                        ev_sent = 1'b1;
                        if (!chip_en) begin
                            state_nx = MODE_IDLE1;
                        end else if (!fifo_empty) begin
                            state_nx  = MODE_TXSET;
                            tmr_load  = 1'b1;
                            retry_clr = 1'b1;
                        end else begin
                            state_nx = MODE_IDLE2;
                        end
                    end else if (tmr_expired) begin
                        lost_inc = 1'b1;
                        if (retry_cnt < retry_limit) begin
                            state_nx = MODE_BACKOFF;
                            tmr_load = 1'b1;
                            tmr_len  = backoff_len;
                        end else begin
                            state_nx = MODE_IDLE1;
                            ev_maxrt = 1'b1;
                        end
                    end
                end
                MODE_BACKOFF: begin
                    if (tmr_expired) begin
                        state_nx  = MODE_TXSET;
                        tmr_load  = 1'b1;
                        retry_inc = 1'b1;
                    end
                end
                default: state_nx = MODE_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= MODE_OFF;
        else
            state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_start     <= 1'b0;
            rx_enable    <= 1'b0;
            sent_pulse   <= 1'b0;
            max_rt_pulse <= 1'b0;
            max_rt_flag  <= 1'b0;
        end else begin
            tx_start     <= launch;
            rx_enable    <= (state_nx == MODE_RXWAIT);
            sent_pulse   <= ev_sent;
            max_rt_pulse <= ev_maxrt;
            if (ev_maxrt)
                max_rt_flag <= 1'b1;
            else if (maxrt_clear)
                max_rt_flag <= 1'b0;
        end
    end

    assign mode = state;

    assert_power_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> state == MODE_OFF);
    assert_start_in_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> state == MODE_TX);
    assert_tx_via_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_TX && $past(state) != MODE_TX) |-> $past(state) == MODE_TXSET);
    assert_rx_only_waiting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> state == MODE_RXWAIT);
    assert_retry_from_backoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != $past(retry_cnt) && retry_cnt != '0) |-> $past(state) == MODE_BACKOFF);
    assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (max_rt_flag && (state == MODE_IDLE1 || state == MODE_IDLE2)) |=> state != MODE_TXSET);
    assert_events_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(sent_pulse && max_rt_pulse));
endmodule

// File: tb/ptx_mode_ctrl_bench.sv
`timescale 1ns/1ps
module ptx_mode_ctrl_bench;
    localparam int SETTLE = 130;
    localparam int ACKW   = 250;
    localparam int STEP   = 250;
    localparam int EV_TX = 1, EV_SENT = 2, EV_MAX = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, us_tick, pwr_up, chip_en, fifo_empty, no_ack_flag, auto_ack_en;
    logic [3:0] retry_delay, retry_limit;
    logic       tx_done, ack_rcvd, chan_write, maxrt_clear;
    logic [2:0] mode;
    logic       tx_start, rx_enable, sent_pulse, max_rt_pulse, max_rt_flag;
    logic [3:0] retry_cnt, lost_cnt;

    ptx_mode_ctrl u_ptx_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pwr_up(pwr_up),
        .chip_en(chip_en), .fifo_empty(fifo_empty), .no_ack_flag(no_ack_flag),
        .auto_ack_en(auto_ack_en), .retry_delay(retry_delay), .retry_limit(retry_limit),
        .tx_done(tx_done), .ack_rcvd(ack_rcvd), .chan_write(chan_write),
        .maxrt_clear(maxrt_clear), .mode(mode), .tx_start(tx_start),
        .rx_enable(rx_enable), .retry_cnt(retry_cnt), .lost_cnt(lost_cnt),
        .sent_pulse(sent_pulse), .max_rt_pulse(max_rt_pulse), .max_rt_flag(max_rt_flag)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    int expq[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic expect_ev(int code);
        expq.push_back(code);
    endtask

    task automatic sb_pop(int code);
        int want;
        if (expq.size() == 0) begin
            check(1'b0, "R13", "unexpected event", code, 0);
        end else begin
            want = expq.pop_front();
            check(want == code, "R13", "event order", code, want);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done_flag) begin
            if (sent_pulse && max_rt_pulse)
                check(1'b0, "R13", "sent and max-retry together", 1, 0);
            if (max_rt_pulse) sb_pop(EV_MAX);
            if (sent_pulse)   sb_pop(EV_SENT);
            if (tx_start)     sb_pop(EV_TX);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        report();
    end

    task automatic wait_mode(int m, int lim, string req);
        int k = 0;
        while (mode !== 3'(m) && k < lim) begin
            @(negedge clk);
            k++;
        end
        check(mode === 3'(m), req, "mode reached", int'(mode), m);
    endtask

    task automatic measure(int m, output int n);
        n = 0;
        while (mode === 3'(m) && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_done();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_rcvd = 1'b1;
        @(negedge clk);
        ack_rcvd = 1'b0;
    endtask

    task automatic pulse_chan();
        chan_write = 1'b1;
        @(negedge clk);
        chan_write = 1'b0;
    endtask

    task automatic pulse_clear();
        maxrt_clear = 1'b1;
        @(negedge clk);
        maxrt_clear = 1'b0;
    endtask

    initial begin
        int n;
        rst_n = 1'b0; us_tick = 1'b1; pwr_up = 1'b0; chip_en = 1'b0;
        fifo_empty = 1'b1; no_ack_flag = 1'b0; auto_ack_en = 1'b0;
        retry_delay = 4'd0; retry_limit = 4'd3; tx_done = 1'b0; ack_rcvd = 1'b0;
        chan_write = 1'b0; maxrt_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode == 3'd0, "R1", "mode", int'(mode), 0);
        check(retry_cnt == 0 && lost_cnt == 0, "R1", "counters", int'(retry_cnt) + int'(lost_cnt), 0);
        check(!max_rt_flag && !rx_enable && !tx_start && !sent_pulse, "R1", "flags", int'(max_rt_flag), 0);

        // R2 power-up wait
        pwr_up = 1'b1;
        repeat (1400) @(negedge clk);
        check(mode == 3'd0, "R2", "still starting", int'(mode), 0);
        wait_mode(1, 200, "R2");

        // R3 short enable pulse is ignored
        fifo_empty = 1'b0;
        chip_en = 1'b1;
        repeat (5) @(negedge clk);
        chip_en = 1'b0;
        repeat (200) @(negedge clk);
        check(mode == 3'd1, "R3", "short enable no launch", int'(mode), 1);

        // R3/R4 qualified launch through settle
        expect_ev(EV_TX);
        chip_en = 1'b1;
        repeat (8) @(negedge clk);
        check(mode == 3'd1, "R3", "enable not yet qualified", int'(mode), 1);
        wait_mode(3, 20, "R3");
        measure(3, n);
        check(n >= SETTLE && n <= SETTLE + 2, "R4", "settle length", n, SETTLE + 1);
        check(mode == 3'd4, "R4", "in TX after settle", int'(mode), 4);

        // R5 finish with empty FIFO -> standby-II
        fifo_empty = 1'b1;
        expect_ev(EV_SENT);
        pulse_done();
        check(mode == 3'd2, "R5", "empty fifo to standby-II", int'(mode), 2);

        // R6 new packet in standby-II
        expect_ev(EV_TX);
        fifo_empty = 1'b0;
        wait_mode(3, 5, "R6");
        wait_mode(4, 200, "R4");

        // R5 back-to-back packet stays in TX
        expect_ev(EV_SENT);
        expect_ev(EV_TX);
        pulse_done();
        check(mode == 3'd4, "R5", "next packet stays in TX", int'(mode), 4);
        repeat (2) @(negedge clk);

        // R5 finish with enable low -> standby-I
        chip_en = 1'b0;
        expect_ev(EV_SENT);
        pulse_done();
        check(mode == 3'd1, "R5", "enable low to standby-I", int'(mode), 1);

        // R7 acknowledgement path
        auto_ack_en = 1'b1;
        chip_en = 1'b1;
        expect_ev(EV_TX);
        wait_mode(3, 30, "R3");
        wait_mode(4, 200, "R4");
        pulse_done();
        check(mode == 3'd5, "R7", "rx settle after TX", int'(mode), 5);
        wait_mode(6, 200, "R7");
        check(rx_enable == 1'b1, "R7", "rx_enable in wait", int'(rx_enable), 1);
        repeat (20) @(negedge clk);
        fifo_empty = 1'b1;
        expect_ev(EV_SENT);
        pulse_ack();
        check(mode == 3'd2, "R7", "ack with empty fifo", int'(mode), 2);
        check(rx_enable == 1'b0, "R7", "rx_enable off", int'(rx_enable), 0);

        // R6 enable low leaves standby-II
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        check(mode == 3'd1, "R6", "enable low to standby-I", int'(mode), 1);

        // R7 no-ack flag skips the receive wait
        chip_en = 1'b1;
        no_ack_flag = 1'b1;
        fifo_empty = 1'b0;
        expect_ev(EV_TX);
        wait_mode(4, 300, "R4");
        fifo_empty = 1'b1;
        expect_ev(EV_SENT);
        pulse_done();
        check(mode == 3'd2, "R7", "no-ack packet skips RX", int'(mode), 2);
        no_ack_flag = 1'b0;

        // R8/R9 retries with two delays
        retry_limit = 4'd2;
        retry_delay = 4'd0;
        expect_ev(EV_TX);
        fifo_empty = 1'b0;
        wait_mode(4, 300, "R4");
        pulse_done();
        wait_mode(6, 300, "R7");
        measure(6, n);
        check(n >= ACKW && n <= ACKW + 2, "R8", "ack window", n, ACKW + 1);
        check(mode == 3'd7, "R9", "backoff after loss", int'(mode), 7);
        check(lost_cnt == 4'd1, "R8", "lost count", int'(lost_cnt), 1);
        measure(7, n);
        check(n >= STEP && n <= STEP + 2, "R9", "backoff delay 0", n, STEP + 1);
        check(retry_cnt == 4'd1, "R9", "retry count", int'(retry_cnt), 1);
        expect_ev(EV_TX);
        wait_mode(4, 300, "R4");
        pulse_done();
        wait_mode(6, 300, "R7");
        retry_delay = 4'd3;
        wait_mode(7, 400, "R9");
        measure(7, n);
        check(n >= 4 * STEP && n <= 4 * STEP + 2, "R9", "backoff delay 3", n, 4 * STEP + 1);
        check(retry_cnt == 4'd2, "R9", "retry count", int'(retry_cnt), 2);
        expect_ev(EV_TX);
        wait_mode(4, 300, "R4");
        pulse_done();
        wait_mode(6, 300, "R7");
        expect_ev(EV_MAX);
        wait_mode(1, 400, "R9");
        check(max_rt_flag == 1'b1, "R9", "flag set", int'(max_rt_flag), 1);
        check(lost_cnt == 4'd3, "R8", "lost count", int'(lost_cnt), 3);

        // R10 lockout then clear; R11 retry counter restarts
        repeat (300) @(negedge clk);
        check(mode == 3'd1, "R10", "locked out", int'(mode), 1);
        expect_ev(EV_TX);
        pulse_clear();
        wait_mode(4, 300, "R10");
        check(retry_cnt == 4'd0, "R11", "retry reset on new packet", int'(retry_cnt), 0);
        pulse_done();
        wait_mode(6, 300, "R7");
        fifo_empty = 1'b1;
        expect_ev(EV_SENT);
        pulse_ack();
        check(mode == 3'd2, "R7", "ack to standby-II", int'(mode), 2);

        // R12 channel write clears losses
        pulse_chan();
        check(lost_cnt == 4'd0, "R12", "lost cleared", int'(lost_cnt), 0);

        // R8 saturation over sixteen losses
        retry_limit = 4'd15;
        retry_delay = 4'd0;
        pulse_chan();
        expect_ev(EV_TX);
        fifo_empty = 1'b0;
        wait_mode(4, 300, "R4");
        for (int i = 0; i < 16; i++) begin
            pulse_done();
            wait_mode(6, 300, "R7");
            if (i < 15) begin
                expect_ev(EV_TX);
                wait_mode(7, 400, "R9");
                wait_mode(4, 700, "R4");
            end else begin
                expect_ev(EV_MAX);
                wait_mode(1, 400, "R9");
            end
        end
        check(lost_cnt == 4'd15, "R8", "lost saturates", int'(lost_cnt), 15);
        check(retry_cnt == 4'd15, "R9", "retries used", int'(retry_cnt), 15);
        pulse_chan();
        check(lost_cnt == 4'd0, "R12", "lost cleared after saturation", int'(lost_cnt), 0);

        // R9 limit zero disables retries
        retry_limit = 4'd0;
        expect_ev(EV_TX);
        pulse_clear();
        wait_mode(4, 300, "R10");
        pulse_done();
        wait_mode(6, 300, "R7");
        expect_ev(EV_MAX);
        wait_mode(1, 400, "R9");
        check(lost_cnt == 4'd1 && retry_cnt == 4'd0, "R9", "no retry at limit 0", int'(lost_cnt), 1);

        // R2 power removal
        pwr_up = 1'b0;
        @(negedge clk);
        check(mode == 3'd0, "R2", "power down", int'(mode), 0);
        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R13", "pending events", expq.size(), 0);
        report();
    end
endmodule